// File: doc/BRIEF.md
# Amplifier Fault Protection Supervisor

This block decides how a stereo switching power stage responds to faults. It takes a shutdown request, a mute request, an undervoltage indication, an over-current event, an output-DC indication, a junction temperature code and a slow time-base tick. From these it produces an output-stage enable, a power-limit request, a mute request, and a protection flag. The mute request forces both bridge halves to equal duty, so the differential output is zero. The flag can be driven low, driven high, or released to high impedance.

Over-current and persistent output DC are latched. They stay latched until the stage is shut down or loses supply. Over-temperature is handled in two tiers that share one release point, and both tiers recover on their own. DC monitoring is suspended while the output is muted. When several conditions are present at once, a fixed priority decides which one sets the outputs.

The temperature code is read directly in degrees Celsius. The tick period sets the time scale of the DC persistence window. For example, a 0.1 s tick and a limit of 5 ticks give a window of just over 0.5 s.

Top module: `amp_guard_top`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, every output is 0: stage off, no mute, no power limit, flag released (`flag_oe`=0).
- R2: With `uvlo` high, all outputs go to 0 (flag high-impedance) one clock after it is sampled, whatever the other inputs are. Undervoltage also clears every latched fault.
- R3: With `shdn_n` low, the stage is off and the flag is driven (`flag_oe`=1) one clock later. The flag level is 1 unless thermal shutdown is active. Shutdown clears the latched over-current and DC faults, so normal operation resumes one clock after `shdn_n` returns high.
- R4: An `oc_evt` pulse sampled while the block is enabled turns the stage off and drives the flag low two clocks later. This state persists after the pulse ends, until shutdown or undervoltage.
- R5: The DC fault latches on the tick where `dc_seen` has been high for more than `DC_TICKS` ticks. With the default of 5, this is the 6th consecutive tick at which `dc_seen` is high. The stage then goes off and the flag low one clock later, and this persists after `dc_seen` falls, until shutdown.
- R6: If `dc_seen` is low in any cycle, the DC tick count restarts from zero.
- R7: While `mute_in` is high, the DC count is held at zero and no DC fault can be raised.
- R8: If the temperature exceeds `T_LIMIT_ON` (155) without exceeding `T_SHUT_ON` (165), the block raises `pwr_limit` with the stage enabled and the flag high. This continues until the temperature is at or below `T_RELEASE` (130). The flag is never pulled low for this condition.
- R9: A temperature above `T_SHUT_ON` turns the stage off and drives the flag low. This holds while the temperature stays at or above `T_RELEASE`, and clears automatically once it is below `T_RELEASE`. No shutdown is needed to clear it.
- R10: `mute_in` high gives `out_en`=1 and `mute_req`=1 one clock later. Release restores normal drive one clock after `mute_in` falls.
- R11: When conditions overlap, the outputs follow this priority: undervoltage, shutdown, over-current, thermal shutdown, DC fault, mute, thermal limit. A blocked lower-priority condition shows no output of its own, so `mute_req` and `pwr_limit` are never both high.
- R12: With no condition active, `out_en`=1, `flag_oe`=1, `flag_lvl`=1, and `mute_req`=`pwr_limit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| shdn_n | input | 1 | Shutdown request, active low |
| uvlo | input | 1 | Supply undervoltage indication |
| oc_evt | input | 1 | Over-current event |
| dc_seen | input | 1 | DC present at the output |
| mute_in | input | 1 | Mute request, active high |
| tick | input | 1 | One-cycle pulse of the slow time base |
| temp_code | input | TEMP_W | Junction temperature in °C |
| out_en | output | 1 | Output stage enable |
| mute_req | output | 1 | Force both outputs to 50% duty |
| pwr_limit | output | 1 | Request 6 dB power reduction |
| flag_oe | output | 1 | Protection flag driven (0 = high impedance) |
| flag_lvl | output | 1 | Protection flag level when driven |

## Verification
The DC window is tested with three patterns: an unbroken run that stops one tick short of the limit, an unbroken run that reaches it, and a run with a one-cycle gap in the middle. Together these separate a true restart from a counter that only pauses, and they pin down the off-by-one at the threshold. The temperature is swept up and down across the 130, 155 and 165 points, and the bench lands exactly on each threshold code. This shows whether the two tiers use the right strict and non-strict comparisons, and whether each tier releases only at the shared point. Overlapping stimuli cover the priority order: mute with thermal limit, over-current while muted, undervoltage on top of a latched fault, and DC while muted. These show which condition owns the outputs and whether the latches clear.

// File: rtl/amp_guard_pkg.sv
package amp_guard_pkg;

  typedef enum logic [1:0] {
    TH_NORM  = 2'd0,
    TH_LIMIT = 2'd1,
    TH_SHUT  = 2'd2
  } therm_e;

  typedef struct packed {
    logic out_en;
    logic mute;
    logic plim;
    logic flag_oe;
    logic flag_lvl;
  } drive_t;

  localparam drive_t DRV_HIZ = '{out_en: 1'b0, mute: 1'b0, plim: 1'b0, flag_oe: 1'b0, flag_lvl: 1'b0};

endpackage

// File: rtl/amp_guard_dc_timer.sv
module amp_guard_dc_timer #(
  parameter int DC_TICKS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic dc,
  input  logic mute,
  input  logic tick,
  output logic fault
);
  localparam int CW = $clog2(DC_TICKS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DC_TICKS);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt   <= '0;
      fault <= 1'b0;
    end else if (!fault) begin
      if (!dc || mute) begin
        cnt <= '0;
      end else if (tick) begin
        if (cnt == LIMIT) fault <= 1'b1;
        else              cnt   <= cnt + 1'b1;
      end
    end
  end

  // R6: a low DC indication restarts the window
  a_r6_restart: assert property (@(posedge clk) disable iff (rst)
    (!dc && !fault) |=> (cnt == '0));

  // R7: muted output never raises a DC fault
  a_r7_mute_masks: assert property (@(posedge clk) disable iff (rst)
    (mute && !fault) |=> !fault);

  // R5: fault stays latched until cleared
  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    (fault && !clr) |=> fault);

endmodule

// File: rtl/amp_guard_thermal.sv
module amp_guard_thermal
  import amp_guard_pkg::*;
#(
  parameter int TEMP_W    = 8,
  parameter int T_LIMIT_ON = 155,
  parameter int T_SHUT_ON  = 165,
  parameter int T_RELEASE  = 130
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TEMP_W-1:0] temp,
  output therm_e            state
);
  localparam logic [TEMP_W-1:0] LIM_C = TEMP_W'(T_LIMIT_ON);
  localparam logic [TEMP_W-1:0] SHT_C = TEMP_W'(T_SHUT_ON);
  localparam logic [TEMP_W-1:0] REL_C = TEMP_W'(T_RELEASE);

  therm_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      TH_NORM: begin
        if (temp > SHT_C)      nxt = TH_SHUT;
        else if (temp > LIM_C) nxt = TH_LIMIT;
      end
      TH_LIMIT: begin
        if (temp > SHT_C)       nxt = TH_SHUT;
        else if (temp <= REL_C) nxt = TH_NORM;
      end
      TH_SHUT: begin
        if (temp < REL_C) nxt = TH_NORM;
      end
      default: nxt = TH_NORM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= TH_NORM;
    else     state <= nxt;
  end

  // R9: thermal shutdown holds until below the release point
  a_r9_shut_hold: assert property (@(posedge clk) disable iff (rst)
    (state == TH_SHUT && temp >= REL_C) |=> (state == TH_SHUT));

  // R8: the limit tier holds above the release point unless escalated
  a_r8_limit_hold: assert property (@(posedge clk) disable iff (rst)
    (state == TH_LIMIT && temp > REL_C && temp <= SHT_C) |=> (state == TH_LIMIT));

  // R8: no tier entered from normal at or below the limit point
  a_r8_norm_hold: assert property (@(posedge clk) disable iff (rst)
    (state == TH_NORM && temp <= LIM_C) |=> (state == TH_NORM));

endmodule

// File: rtl/amp_guard_sticky.sv
module amp_guard_sticky #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [WIDTH-1:0] set,
  output logic [WIDTH-1:0] q
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || clr)  q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
    end

    // R4: a set bit stays set until cleared
    a_r4_hold: assert property (@(posedge clk) disable iff (rst)
      (q[i] && !clr) |=> q[i]);
  end

endmodule

// File: rtl/amp_guard_top.sv
module amp_guard_top
  import amp_guard_pkg::*;
#(
  parameter int TEMP_W     = 8,
  parameter int T_LIMIT_ON = 155,
  parameter int T_SHUT_ON  = 165,
  parameter int T_RELEASE  = 130,
  parameter int DC_TICKS   = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              shdn_n,
  input  logic              uvlo,
  input  logic              oc_evt,
  input  logic              dc_seen,
  input  logic              mute_in,
  input  logic              tick,
  input  logic [TEMP_W-1:0] temp_code,
  output logic              out_en,
  output logic              mute_req,
  output logic              pwr_limit,
  output logic              flag_oe,
  output logic              flag_lvl
);
  logic   clr_all;
  logic   oc_q;
  logic   dc_fault;
  therm_e th_state;
  drive_t drv_nxt, drv_q;

  assign clr_all = uvlo || !shdn_n;

  amp_guard_sticky #(.WIDTH(1)) u_oc (
    .clk (clk),
    .rst (rst),
    .clr (clr_all),
    .set (oc_evt),
    .q   (oc_q)
  );

  amp_guard_dc_timer #(.DC_TICKS(DC_TICKS)) u_dc (
    .clk   (clk),
    .rst   (rst),
    .clr   (clr_all),
    .dc    (dc_seen),
    .mute  (mute_in),
    .tick  (tick),
    .fault (dc_fault)
  );

  amp_guard_thermal #(
    .TEMP_W     (TEMP_W),
    .T_LIMIT_ON (T_LIMIT_ON),
    .T_SHUT_ON  (T_SHUT_ON),
    .T_RELEASE  (T_RELEASE)
  ) u_th (
    .clk   (clk),
    .rst   (rst),
    .temp  (temp_code),
    .state (th_state)
  );

  // fixed priority resolution of the output drive
  always_comb begin
    drv_nxt = DRV_HIZ;
    if (uvlo) begin
      drv_nxt = DRV_HIZ;
    end else if (!shdn_n) begin
      drv_nxt.flag_oe  = 1'b1;
      drv_nxt.flag_lvl = (th_state != TH_SHUT);
    end else if (oc_q || th_state == TH_SHUT || dc_fault) begin
      drv_nxt.flag_oe  = 1'b1;
      drv_nxt.flag_lvl = 1'b0;
    end else begin
      drv_nxt.out_en   = 1'b1;
      drv_nxt.flag_oe  = 1'b1;
      drv_nxt.flag_lvl = 1'b1;
      if (mute_in)                    drv_nxt.mute = 1'b1;
      else if (th_state == TH_LIMIT)  drv_nxt.plim = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) drv_q <= DRV_HIZ;
    else     drv_q <= drv_nxt;
  end

  assign out_en    = drv_q.out_en;
  assign mute_req  = drv_q.mute;
  assign pwr_limit = drv_q.plim;
  assign flag_oe   = drv_q.flag_oe;
  assign flag_lvl  = drv_q.flag_lvl;

  // R2: undervoltage releases the flag and stops the stage
  a_r2_uvlo_hiz: assert property (@(posedge clk) disable iff (rst)
    uvlo |=> (!flag_oe && !out_en));

  // R3: shutdown stops the stage with the flag driven
  a_r3_shdn_off: assert property (@(posedge clk) disable iff (rst)
    (!shdn_n && !uvlo) |=> (!out_en && flag_oe));

  // R4: an accepted over-current event stops the stage two clocks later
  a_r4_oc_off: assert property (@(posedge clk) disable iff (rst)
    (oc_evt && shdn_n && !uvlo) |-> ##2 !out_en);

  // R10: mute only with the stage enabled
  a_r10_mute_en: assert property (@(posedge clk) disable iff (rst)
    mute_req |-> out_en);

  // R11: mute and power limit never together
  a_r11_excl: assert property (@(posedge clk) disable iff (rst)
    !(mute_req && pwr_limit));

  // R9: thermal shutdown keeps the flag from reading high
  a_r9_flag_low: assert property (@(posedge clk) disable iff (rst)
    (th_state == TH_SHUT && !uvlo) |=> (flag_oe && !flag_lvl));

endmodule

// File: tb/amp_guard_top_test.sv
module amp_guard_top_test;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       shdn_n = 1'b1;
  logic       uvlo = 1'b0;
  logic       oc_evt = 1'b0;
  logic       dc_seen = 1'b0;
  logic       mute_in = 1'b0;
  logic       tick = 1'b0;
  logic [7:0] temp_code = 8'd40;
  logic       out_en, mute_req, pwr_limit, flag_oe, flag_lvl;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  // expected vector: {out_en, mute_req, pwr_limit, flag_oe, flag_lvl}
  localparam logic [4:0] E_RUN  = 5'b10011;
  localparam logic [4:0] E_FLT  = 5'b00010;
  localparam logic [4:0] E_MUTE = 5'b11011;
  localparam logic [4:0] E_LIM  = 5'b10111;
  localparam logic [4:0] E_SHDN = 5'b00011;
  localparam logic [4:0] E_HIZ  = 5'b00000;

  logic [4:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  amp_guard_top uut (
    .clk(clk), .rst(rst), .shdn_n(shdn_n), .uvlo(uvlo), .oc_evt(oc_evt),
    .dc_seen(dc_seen), .mute_in(mute_in), .tick(tick), .temp_code(temp_code),
    .out_en(out_en), .mute_req(mute_req), .pwr_limit(pwr_limit),
    .flag_oe(flag_oe), .flag_lvl(flag_lvl)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_now(input string tag, input logic [4:0] e);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic pulse_tick();
    tick = 1'b1;
    step(1);
    tick = 1'b0;
  endtask

  // monitor: pops expected items and compares with the outputs
  initial begin
    forever begin
      wait (exp_q.size() != 0);
      begin
        logic [4:0] e;
        logic [4:0] a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a = {out_en, mute_req, pwr_limit, flag_oe, flag_lvl};
        checks++;
        if (a !== e) begin
          failures++;
          $display("FAIL %s actual=%b expected=%b", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    expect_now("R1 in reset", E_HIZ);
    step(1);
    rst = 1'b0;
    step(1);
    expect_now("R12 normal after reset", E_RUN);

    // R10 mute and release
    mute_in = 1'b1; step(1);
    expect_now("R10 mute on", E_MUTE);
    mute_in = 1'b0; step(1);
    expect_now("R10 mute release", E_RUN);

    // R4 over-current latches
    oc_evt = 1'b1; step(1); oc_evt = 1'b0;
    expect_now("R4 one clock after event, still running", E_RUN);
    step(1);
    expect_now("R4 off and flag low", E_FLT);
    step(5);
    expect_now("R4 still latched", E_FLT);
    // R3 shutdown clears latch
    shdn_n = 1'b0; step(1);
    expect_now("R3 shutdown state", E_SHDN);
    shdn_n = 1'b1; step(1);
    expect_now("R3 resume after shutdown", E_RUN);

    // R2 undervoltage over a latched fault
    oc_evt = 1'b1; step(1); oc_evt = 1'b0; step(1);
    expect_now("R4 latched before uvlo", E_FLT);
    uvlo = 1'b1; step(1);
    expect_now("R2 flag high impedance", E_HIZ);
    uvlo = 1'b0; step(1);
    expect_now("R2 latch cleared by uvlo", E_RUN);

    // R5 DC window: limit not yet exceeded after 5 ticks
    dc_seen = 1'b1;
    for (int i = 0; i < 5; i++) begin pulse_tick(); step(1); end
    step(1);
    expect_now("R5 no fault at 5 ticks", E_RUN);
    pulse_tick(); step(1);
    expect_now("R5 fault at 6th tick", E_FLT);
    dc_seen = 1'b0; step(3);
    expect_now("R5 DC fault latched", E_FLT);
    shdn_n = 1'b0; step(1); shdn_n = 1'b1; step(1);
    expect_now("R5 shutdown clears DC fault", E_RUN);

    // R6 restart on a gap
    dc_seen = 1'b1;
    for (int i = 0; i < 3; i++) begin pulse_tick(); step(1); end
    dc_seen = 1'b0; step(1); dc_seen = 1'b1;
    for (int i = 0; i < 5; i++) begin pulse_tick(); step(1); end
    step(1);
    expect_now("R6 restarted count, no fault", E_RUN);
    pulse_tick(); step(1);
    expect_now("R6 fault after full window", E_FLT);
    dc_seen = 1'b0;
    shdn_n = 1'b0; step(1); shdn_n = 1'b1; step(1);
    expect_now("R6 cleared", E_RUN);

    // R7 mute masks DC
    mute_in = 1'b1; dc_seen = 1'b1;
    for (int i = 0; i < 9; i++) begin pulse_tick(); step(1); end
    expect_now("R7 no DC fault while muted", E_MUTE);
    mute_in = 1'b0; step(1);
    expect_now("R7 normal after unmute", E_RUN);
    dc_seen = 1'b0; step(1);

    // R8 thermal limit tier
    temp_code = 8'd155; step(2);
    expect_now("R8 at 155 no limit", E_RUN);
    temp_code = 8'd160; step(2);
    expect_now("R8 limit above 155", E_LIM);
    temp_code = 8'd140; step(2);
    expect_now("R8 limit holds at 140", E_LIM);
    mute_in = 1'b1; step(1);
    expect_now("R11 mute outranks limit", E_MUTE);
    mute_in = 1'b0; step(1);
    temp_code = 8'd130; step(2);
    expect_now("R8 cleared at 130", E_RUN);

    // R9 thermal shutdown tier
    temp_code = 8'd165; step(2);
    expect_now("R9 at 165 only limit", E_LIM);
    temp_code = 8'd170; step(2);
    expect_now("R9 off above 165", E_FLT);
    shdn_n = 1'b0; step(1);
    expect_now("R3 shutdown flag low under thermal shutdown", E_SHDN & 5'b11110);
    shdn_n = 1'b1;
    temp_code = 8'd130; step(2);
    expect_now("R9 holds at 130", E_FLT);
    temp_code = 8'd129; step(2);
    expect_now("R9 auto recovery below 130", E_RUN);

    // R11 over-current outranks mute
    mute_in = 1'b1; step(1);
    oc_evt = 1'b1; step(1); oc_evt = 1'b0; step(1);
    expect_now("R11 oc outranks mute", E_FLT);
    mute_in = 1'b0;
    shdn_n = 1'b0; step(1); shdn_n = 1'b1; step(1);
    expect_now("R12 normal at end", E_RUN);

    wait (exp_q.size() == 0);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule